// File: doc/BRIEF.md
# PCM Serial Sample Transceiver

This block moves audio samples between a parallel system side and a serial PCM codec link. In every frame it captures one receive word from the serial data input and shifts one transmit word out onto the serial data output. The bit clock and frame sync arrive as inputs. They may come from a companion clock generator or from an external bus master, and the block samples them with its own system clock. The system clock must run at least twice as fast as the bit clock.

Each direction has its own word length, its own bit order and its own start position within the frame. The position is counted in bit clocks from the sample edge that sees frame sync become active. Static configuration inputs choose which bit-clock edge samples data, whether frame sync is active low, and whether the output is held at high impedance at all times. That last setting lets several slaves share one data line. The output driver is represented by a data bit plus an output-enable.

Top module: `pcm_xcvr`

## Requirements
- R1: The receive and transmit bit orders are chosen separately by `cfg_rx_lsb_first` and `cfg_tx_lsb_first`. A value of 1 means least-significant bit first and 0 means most-significant bit first. The two settings may differ.
- R2: Least-significant-first order is honoured only when the length field is 23 or less, which is 24 bits or fewer. For longer words the direction runs most-significant-first, whatever the order bit says.
- R3: Each direction's word length is its 5-bit length field plus one, giving 1 to 32 bits. The two lengths are independent.
- R4: Sample edges are numbered from 0, where edge 0 is the one that first sees frame sync active. Receive bit k is captured on sample edge `cfg_rx_offset + k`. Transmit bit k is launched on the launch edge that follows sample edge `cfg_tx_offset + k`.
- R5: `pcm_dout_oe_o` is high only while a transmit bit is being driven. It is low before the slot, after the slot and between words.
- R6: While `cfg_force_hiz` is 1, `pcm_dout_oe_o` stays low from the next clock on. Queued words are still consumed and receive continues.
- R7: Reset is synchronous and active high. After reset the output enable is low, `rx_valid_o` and `tx_underrun_o` are low and `tx_ready_o` is high.
- R8: `cfg_sample_fall` set to 0 samples data and frame sync on the rising bit-clock edge and launches on the falling edge. Set to 1, it swaps the two edges.
- R9: `cfg_fsync_inv` set to 1 makes a low frame-sync level the active one.
- R10: A received word appears right-justified on `rx_data_o`, with the upper bits zero. `rx_valid_o` pulses for exactly one clock after the last bit is captured.
- R11: If no transmit word is held when a slot starts, `tx_underrun_o` pulses for one clock and the output stays disabled for that slot.
- R12: The transmit side holds one word. `tx_ready_o` falls after a `tx_valid_i`/`tx_ready_o` transfer and rises again once the word is loaded at its slot start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pcm_bclk_i | input | 1 | Serial bit clock |
| pcm_fsync_i | input | 1 | Frame sync |
| pcm_din_i | input | 1 | Serial receive data |
| pcm_dout_o | output | 1 | Serial transmit data |
| pcm_dout_oe_o | output | 1 | Output enable for transmit data |
| cfg_sample_fall | input | 1 | 1: sample on the falling edge, launch on the rising edge |
| cfg_fsync_inv | input | 1 | 1: frame sync is active low |
| cfg_force_hiz | input | 1 | 1: output always disabled |
| cfg_rx_lsb_first | input | 1 | Receive order request |
| cfg_rx_len_m1 | input | 5 | Receive length minus one |
| cfg_rx_offset | input | 8 | Receive start offset in bit clocks |
| cfg_tx_lsb_first | input | 1 | Transmit order request |
| cfg_tx_len_m1 | input | 5 | Transmit length minus one |
| cfg_tx_offset | input | 8 | Transmit start offset in bit clocks |
| tx_data_i | input | 32 | Transmit word, right-justified |
| tx_valid_i | input | 1 | Transmit word valid |
| tx_ready_o | output | 1 | Holding register free |
| tx_underrun_o | output | 1 | One-clock pulse when a slot starts empty |
| rx_data_o | output | 32 | Received word, right-justified |
| rx_valid_o | output | 1 | One-clock pulse per received word |

## Verification
Asymmetric words pass through both directions at once: MSB-first receive against LSB-first transmit, and lengths of 1, 8, 10, 12, 16, 20, 24, 25 and 32 bits at different offsets. A fault in one direction's order, length or offset therefore cannot be hidden by the other direction. Pairs of lengths on either side of 24 bits separate an honoured order request from a forced one. The inverted-edge, active-low-sync case shows whether the edge and polarity choices are really swapped. A frame with force-hiz, and a frame with nothing queued, show whether the enable is gated by the override or by the holding register.

// File: rtl/pcm_xcvr_pkg.sv
package pcm_xcvr_pkg;

  typedef enum logic {
    TX_IDLE  = 1'b0,
    TX_SHIFT = 1'b1
  } tx_state_t;

  // LSB-first order only applies to short words; longer words fall back to MSB-first
  function automatic logic lsb_allowed(input logic req, input int unsigned len_m1,
                                       input int unsigned lsb_max);
    return req && (len_m1 < lsb_max);
  endfunction

endpackage

// File: rtl/pcm_edge_timing.sv
module pcm_edge_timing #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bclk_i,
  input  logic             fsync_i,
  input  logic             cfg_sample_fall,
  input  logic             cfg_fsync_inv,
  output logic             smp_evt,
  output logic             drv_evt,
  output logic             frame_start,
  output logic             in_frame,
  output logic [CNT_W-1:0] bit_idx,
  output logic [CNT_W-1:0] smp_idx
);

  logic bclk_q, fs_prev_q, fs_act, rise, fall;

  assign rise        = bclk_i & ~bclk_q;
  assign fall        = ~bclk_i & bclk_q;
  assign smp_evt     = cfg_sample_fall ? fall : rise;
  assign drv_evt     = cfg_sample_fall ? rise : fall;
  assign fs_act      = fsync_i ^ cfg_fsync_inv;
  assign frame_start = smp_evt & fs_act & ~fs_prev_q;

  // index of the sample edge happening in this cycle
  always_comb begin
    if (frame_start)          smp_idx = '0;
    else if (bit_idx == '1)   smp_idx = bit_idx;
    else                      smp_idx = bit_idx + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_q    <= 1'b0;
      fs_prev_q <= 1'b0;
      in_frame  <= 1'b0;
      bit_idx   <= '0;
    end else begin
      bclk_q <= bclk_i;
      if (smp_evt) fs_prev_q <= fs_act;
      if (frame_start) begin
        in_frame <= 1'b1;
        bit_idx  <= '0;
      end else if (smp_evt && in_frame) begin
        bit_idx <= smp_idx;
      end
    end
  end

endmodule

// File: rtl/pcm_rx_deser.sv
module pcm_rx_deser
  import pcm_xcvr_pkg::*;
#(
  parameter int          DATA_W  = 32,
  parameter int          OFF_W   = 8,
  parameter int unsigned LSB_MAX = 24,
  localparam int         LEN_W   = $clog2(DATA_W),
  localparam int         CNT_W   = OFF_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_evt,
  input  logic              frame_live,
  input  logic [CNT_W-1:0]  smp_idx,
  input  logic              din,
  input  logic              cfg_lsb,
  input  logic [LEN_W-1:0]  cfg_len_m1,
  input  logic [OFF_W-1:0]  cfg_off,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid
);

  logic [DATA_W-1:0] sr_q, base, nxt;
  logic [CNT_W-1:0]  rel;
  logic [LEN_W:0]    sh;
  logic              in_slot, lsb_eff;

  always_comb begin
    lsb_eff = lsb_allowed(cfg_lsb, 32'(cfg_len_m1), LSB_MAX);
    rel     = smp_idx - CNT_W'(cfg_off);
    in_slot = frame_live && (smp_idx >= CNT_W'(cfg_off)) && (rel <= CNT_W'(cfg_len_m1));
    base    = (rel == '0) ? '0 : sr_q;
    nxt     = lsb_eff ? {din, base[DATA_W-1:1]} : {base[DATA_W-2:0], din};
    sh      = (LEN_W+1)'(DATA_W-1) - (LEN_W+1)'(cfg_len_m1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q     <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (smp_evt && in_slot) begin
        sr_q <= nxt;
        if (rel == CNT_W'(cfg_len_m1)) begin
          rx_data  <= lsb_eff ? (nxt >> sh) : nxt;
          rx_valid <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/pcm_tx_ser.sv
module pcm_tx_ser
  import pcm_xcvr_pkg::*;
#(
  parameter int          DATA_W  = 32,
  parameter int          OFF_W   = 8,
  parameter int unsigned LSB_MAX = 24,
  localparam int         LEN_W   = $clog2(DATA_W),
  localparam int         CNT_W   = OFF_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              drv_evt,
  input  logic              in_frame,
  input  logic [CNT_W-1:0]  bit_idx,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  input  logic              cfg_lsb,
  input  logic [LEN_W-1:0]  cfg_len_m1,
  input  logic [OFF_W-1:0]  cfg_off,
  input  logic              cfg_force_hiz,
  output logic              tx_ready,
  output logic              dout,
  output logic              oe,
  output logic              underrun
);

  tx_state_t         st_q;
  logic              full_q, lsb_eff, at_start;
  logic [DATA_W-1:0] hold_q, shreg_q, aligned;
  logic [CNT_W-1:0]  rel;
  logic [LEN_W:0]    sh;

  always_comb begin
    lsb_eff  = lsb_allowed(cfg_lsb, 32'(cfg_len_m1), LSB_MAX);
    rel      = bit_idx - CNT_W'(cfg_off);
    at_start = in_frame && (bit_idx == CNT_W'(cfg_off));
    sh       = (LEN_W+1)'(DATA_W-1) - (LEN_W+1)'(cfg_len_m1);
    aligned  = hold_q << sh;
  end

  assign tx_ready = ~full_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= TX_IDLE;
      full_q   <= 1'b0;
      hold_q   <= '0;
      shreg_q  <= '0;
      dout     <= 1'b0;
      oe       <= 1'b0;
      underrun <= 1'b0;
    end else begin
      underrun <= 1'b0;
      if (drv_evt && at_start) begin
        if (full_q) begin
          full_q <= 1'b0;
          st_q   <= TX_SHIFT;
          oe     <= 1'b1;
          if (lsb_eff) begin
            dout    <= hold_q[0];
            shreg_q <= hold_q >> 1;
          end else begin
            dout    <= aligned[DATA_W-1];
            shreg_q <= aligned << 1;
          end
        end else begin
          underrun <= 1'b1;
          st_q     <= TX_IDLE;
          oe       <= 1'b0;
        end
      end else if (drv_evt && in_frame && st_q == TX_SHIFT) begin
        if (rel <= CNT_W'(cfg_len_m1)) begin
          dout    <= lsb_eff ? shreg_q[0] : shreg_q[DATA_W-1];
          shreg_q <= lsb_eff ? (shreg_q >> 1) : (shreg_q << 1);
          oe      <= 1'b1;
        end else begin
          st_q <= TX_IDLE;
          oe   <= 1'b0;
        end
      end
      if (tx_valid && !full_q) begin
        hold_q <= tx_data;
        full_q <= 1'b1;
      end
      if (cfg_force_hiz) oe <= 1'b0;
    end
  end

endmodule

// File: rtl/pcm_xcvr.sv
module pcm_xcvr #(
  parameter int          DATA_W  = 32,
  parameter int          OFF_W   = 8,
  parameter int unsigned LSB_MAX = 24,
  localparam int         LEN_W   = $clog2(DATA_W),
  localparam int         CNT_W   = OFF_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pcm_bclk_i,
  input  logic              pcm_fsync_i,
  input  logic              pcm_din_i,
  output logic              pcm_dout_o,
  output logic              pcm_dout_oe_o,
  input  logic              cfg_sample_fall,
  input  logic              cfg_fsync_inv,
  input  logic              cfg_force_hiz,
  input  logic              cfg_rx_lsb_first,
  input  logic [LEN_W-1:0]  cfg_rx_len_m1,
  input  logic [OFF_W-1:0]  cfg_rx_offset,
  input  logic              cfg_tx_lsb_first,
  input  logic [LEN_W-1:0]  cfg_tx_len_m1,
  input  logic [OFF_W-1:0]  cfg_tx_offset,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic              tx_underrun_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o
);

  logic             smp_evt, drv_evt, frame_start, in_frame;
  logic [CNT_W-1:0] bit_idx, smp_idx;

  pcm_edge_timing #(.CNT_W(CNT_W)) u_timing (
    .clk(clk), .rst(rst), .bclk_i(pcm_bclk_i), .fsync_i(pcm_fsync_i),
    .cfg_sample_fall(cfg_sample_fall), .cfg_fsync_inv(cfg_fsync_inv),
    .smp_evt(smp_evt), .drv_evt(drv_evt), .frame_start(frame_start),
    .in_frame(in_frame), .bit_idx(bit_idx), .smp_idx(smp_idx)
  );

  pcm_rx_deser #(.DATA_W(DATA_W), .OFF_W(OFF_W), .LSB_MAX(LSB_MAX)) u_rx (
    .clk(clk), .rst(rst), .smp_evt(smp_evt), .frame_live(frame_start | in_frame),
    .smp_idx(smp_idx), .din(pcm_din_i), .cfg_lsb(cfg_rx_lsb_first),
    .cfg_len_m1(cfg_rx_len_m1), .cfg_off(cfg_rx_offset),
    .rx_data(rx_data_o), .rx_valid(rx_valid_o)
  );

  pcm_tx_ser #(.DATA_W(DATA_W), .OFF_W(OFF_W), .LSB_MAX(LSB_MAX)) u_tx (
    .clk(clk), .rst(rst), .drv_evt(drv_evt), .in_frame(in_frame), .bit_idx(bit_idx),
    .tx_data(tx_data_i), .tx_valid(tx_valid_i), .cfg_lsb(cfg_tx_lsb_first),
    .cfg_len_m1(cfg_tx_len_m1), .cfg_off(cfg_tx_offset), .cfg_force_hiz(cfg_force_hiz),
    .tx_ready(tx_ready_o), .dout(pcm_dout_o), .oe(pcm_dout_oe_o), .underrun(tx_underrun_o)
  );

endmodule

// File: rtl/pcm_xcvr_chk.sv
module pcm_xcvr_chk (
  input logic clk,
  input logic rst,
  input logic drv_evt,
  input logic cfg_force_hiz,
  input logic pcm_dout_oe_o,
  input logic tx_valid_i,
  input logic tx_ready_o,
  input logic tx_underrun_o,
  input logic rx_valid_o
);

  assert_reset_hiz_R7: assert property (@(posedge clk) rst |=> !pcm_dout_oe_o);

  assert_force_hiz_R6: assert property (@(posedge clk) disable iff (rst)
    cfg_force_hiz |=> !pcm_dout_oe_o);

  assert_oe_on_launch_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(pcm_dout_oe_o) |-> $past(drv_evt));

  assert_rx_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    rx_valid_o |=> !rx_valid_o);

  assert_hold_full_R12: assert property (@(posedge clk) disable iff (rst)
    (tx_valid_i && tx_ready_o) |=> !tx_ready_o);

  assert_underrun_hiz_R11: assert property (@(posedge clk) disable iff (rst)
    tx_underrun_o |-> !pcm_dout_oe_o);

endmodule

bind pcm_xcvr pcm_xcvr_chk u_chk (
  .clk(clk), .rst(rst), .drv_evt(drv_evt), .cfg_force_hiz(cfg_force_hiz),
  .pcm_dout_oe_o(pcm_dout_oe_o), .tx_valid_i(tx_valid_i), .tx_ready_o(tx_ready_o),
  .tx_underrun_o(tx_underrun_o), .rx_valid_o(rx_valid_o)
);

// File: tb/pcm_xcvr_tb_top.sv
module pcm_xcvr_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bclk = 1'b0, fsync = 1'b0, din = 1'b0;
  logic        dout, oe, tx_ready, underrun, rx_valid;
  logic [31:0] rx_data;
  logic [31:0] tx_data = '0;
  logic        tx_valid = 1'b0;

  int c_fall = 0, c_fsinv = 0, c_force = 0;
  int c_rx_lsb = 0, c_rx_len = 8, c_rx_off = 0;
  int c_tx_lsb = 0, c_tx_len = 8, c_tx_off = 0;

  int n_chk = 0, n_fail = 0, ur_cnt = 0;
  bit done = 0;
  logic [31:0] exp_rx[$];
  string       exp_tag[$];

  always #10 clk = ~clk;

  pcm_xcvr dut_i (
    .clk(clk), .rst(rst), .pcm_bclk_i(bclk), .pcm_fsync_i(fsync), .pcm_din_i(din),
    .pcm_dout_o(dout), .pcm_dout_oe_o(oe),
    .cfg_sample_fall(c_fall[0]), .cfg_fsync_inv(c_fsinv[0]), .cfg_force_hiz(c_force[0]),
    .cfg_rx_lsb_first(c_rx_lsb[0]), .cfg_rx_len_m1(5'(c_rx_len - 1)), .cfg_rx_offset(8'(c_rx_off)),
    .cfg_tx_lsb_first(c_tx_lsb[0]), .cfg_tx_len_m1(5'(c_tx_len - 1)), .cfg_tx_offset(8'(c_tx_off)),
    .tx_data_i(tx_data), .tx_valid_i(tx_valid), .tx_ready_o(tx_ready),
    .tx_underrun_o(underrun), .rx_data_o(rx_data), .rx_valid_o(rx_valid)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mask_of(input int len);
    return (len == 32) ? 32'hFFFF_FFFF : ((32'd1 << len) - 32'd1);
  endfunction

  // scoreboard monitor: received words against queued expectations
  always @(negedge clk) begin
    if (!rst && underrun) ur_cnt++;
    if (!rst && rx_valid) begin
      if (exp_rx.size() == 0) chk(1'b0, "R10 unexpected rx word", rx_data, 32'h0);
      else begin
        logic [31:0] e;
        string t;
        e = exp_rx.pop_front();
        t = exp_tag.pop_front();
        chk(rx_data === e, {"R10 rx word ", t}, rx_data, e);
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    bclk = c_fall[0] ? 1'b1 : 1'b0;
    fsync = c_fsinv[0];
    tx_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic push_tx(input logic [31:0] w);
    @(negedge clk);
    tx_data = w;
    tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
    chk(tx_ready === 1'b0, "R12 ready low while word held", {31'b0, tx_ready}, 32'h0);
  endtask

  task automatic run_frame(input logic [31:0] rxw, input logic [31:0] txw, input bit push,
                           input string tag);
    int nb, oe_bad, ur0;
    bit rx_eff, tx_eff, exp_oe;
    logic [31:0] tx_got;
    rx_eff = (c_rx_lsb != 0) && (c_rx_len <= 24);
    tx_eff = (c_tx_lsb != 0) && (c_tx_len <= 24);
    if (push) push_tx(txw);
    exp_rx.push_back(rxw & mask_of(c_rx_len));
    exp_tag.push_back(tag);
    nb = ((c_rx_off + c_rx_len) > (c_tx_off + c_tx_len) ? (c_rx_off + c_rx_len)
                                                         : (c_tx_off + c_tx_len)) + 3;
    ur0 = ur_cnt;
    oe_bad = 0;
    tx_got = '0;
    @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      int k, k2;
      fsync = (i == 0) ^ c_fsinv[0];
      k = i - c_rx_off;
      if (k >= 0 && k < c_rx_len) din = rx_eff ? rxw[k] : rxw[c_rx_len - 1 - k];
      else din = 1'b0;
      exp_oe = push && (c_force == 0) && (i >= c_tx_off + 1) && (i <= c_tx_off + c_tx_len);
      if (oe !== exp_oe) oe_bad++;
      k2 = i - c_tx_off - 1;
      if (k2 >= 0 && k2 < c_tx_len) begin
        if (tx_eff) tx_got[k2] = dout;
        else tx_got = {tx_got[30:0], dout};
      end
      bclk = c_fall[0] ? 1'b0 : 1'b1;
      repeat (4) @(negedge clk);
      bclk = c_fall[0] ? 1'b1 : 1'b0;
      repeat (4) @(negedge clk);
    end
    chk(oe_bad == 0, {"R5 enable window ", tag}, 32'(oe_bad), 32'h0);
    if (push && c_force == 0)
      chk(tx_got === (txw & mask_of(c_tx_len)), {"R4 tx word ", tag}, tx_got, txw & mask_of(c_tx_len));
    chk((ur_cnt - ur0) == (push ? 0 : 1), {"R11 underrun count ", tag}, 32'(ur_cnt - ur0),
        push ? 32'h0 : 32'h1);
    chk(exp_rx.size() == 0, {"R10 rx word delivered ", tag}, 32'(exp_rx.size()), 32'h0);
  endtask

  initial begin
    do_reset();
    chk(oe === 1'b0, "R7 enable after reset", {31'b0, oe}, 32'h0);
    chk(rx_valid === 1'b0, "R7 rx_valid after reset", {31'b0, rx_valid}, 32'h0);
    chk(tx_ready === 1'b1, "R7 tx_ready after reset", {31'b0, tx_ready}, 32'h1);
    chk(underrun === 1'b0, "R7 underrun after reset", {31'b0, underrun}, 32'h0);

    // equal 8-bit MSB-first words, back to back
    run_frame(32'hA5, 32'h3C, 1, "R3 8/8 msb");
    run_frame(32'h5A, 32'hC3, 1, "R3 8/8 second frame");

    // mixed orders and lengths with offsets
    c_rx_lsb = 1; c_rx_len = 16; c_rx_off = 3;
    c_tx_lsb = 0; c_tx_len = 12; c_tx_off = 1;
    do_reset();
    run_frame(32'h0000_B1C4, 32'h0000_0A96, 1, "R1 R3 R4 rx lsb16 tx msb12");

    c_rx_lsb = 0; c_rx_len = 32; c_rx_off = 2;
    c_tx_lsb = 1; c_tx_len = 20; c_tx_off = 5;
    do_reset();
    run_frame(32'hC0DE_1234, 32'h0009_3E71, 1, "R1 R3 rx msb32 tx lsb20");

    // order limit boundary: 24 honoured, 25 forced to MSB-first
    c_rx_lsb = 1; c_rx_len = 24; c_rx_off = 1;
    c_tx_lsb = 1; c_tx_len = 25; c_tx_off = 0;
    do_reset();
    run_frame(32'h00E1_0F35, 32'h01A5_0C3F, 1, "R2 rx lsb24 tx lsb25 forced");

    c_rx_lsb = 1; c_rx_len = 32; c_rx_off = 0;
    c_tx_lsb = 1; c_tx_len = 1;  c_tx_off = 0;
    do_reset();
    run_frame(32'h8000_0001, 32'h0000_0001, 1, "R2 R3 rx lsb32 forced tx 1 bit");

    // opposite edges and active-low frame sync
    c_fall = 1; c_fsinv = 1;
    c_rx_lsb = 0; c_rx_len = 10; c_rx_off = 4;
    c_tx_lsb = 1; c_tx_len = 7;  c_tx_off = 2;
    do_reset();
    run_frame(32'h0000_02D3, 32'h0000_0055, 1, "R8 R9 falling sample low sync");
    run_frame(32'h0000_012C, 32'h0000_002A, 1, "R8 R9 second frame");

    // permanent high impedance: word consumed, receive still live
    c_fall = 0; c_fsinv = 0; c_force = 1;
    c_rx_lsb = 0; c_rx_len = 8; c_rx_off = 0;
    c_tx_lsb = 0; c_tx_len = 8; c_tx_off = 0;
    do_reset();
    run_frame(32'h96, 32'hFF, 1, "R6 forced hiz");
    chk(tx_ready === 1'b1, "R6 R12 word consumed under force", {31'b0, tx_ready}, 32'h1);

    // empty holding register at slot start, then recovery
    c_force = 0;
    do_reset();
    run_frame(32'h3E, 32'h00, 0, "R11 no word queued");
    run_frame(32'h71, 32'h9B, 1, "R11 recovery");

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule